// File: doc/BRIEF.md
# Parallel EEPROM Write Sequencer

This block sits on the host side of an asynchronous parallel EEPROM and turns a stream of byte write requests into correctly timed bus write cycles. Requests arrive on a valid/ready port. The block drives the address and data lines, a chip-select, a write strobe and an output-enable. It builds every bus interval from the system clock through cycle-count parameters, which are the nanosecond or microsecond limits divided by the clock period and rounded up.

The device opens a page window at each falling write strobe and restarts it on the next falling strobe. While that window is open, further bytes of the same page may follow. The sequencer keeps its own copy of the window. It joins requests into one burst while a follow-on strobe can still fall inside the window. It closes the burst when the next request targets another page, or when no request has arrived by the last safe cycle. It then releases chip-select and waits until the window has lapsed plus the worst-case programming time. Only after that does it accept the next request.

Back-pressure rules: `in_ready` is high in the idle state. It is also high in the short gap between strobes of an open burst, but only while the window still allows another strobe and only for a request in the current page. `in_ready` is low during the setup, strobe and hold phases and for the whole programming wait. A request transfers on a clock edge where `in_valid` and `in_ready` are both high. The host must hold its request stable until that edge.

Top module: `eeprom_wr_seq`

## Requirements
- R1: During and after reset, `mem_cs_n` and `mem_we_n` are high, `mem_drive` is low and `in_ready` is high.
- R2: `mem_oe_n` is high in every cycle, including every cycle in which `mem_we_n` falls.
- R3: While `mem_we_n` is low, `mem_cs_n` is low and `mem_addr`/`mem_dout` are stable. These values are held for at least SU_CYC cycles before the strobe falls and for at least max(DH_CYC, WPH_CYC) cycles after it rises.
- R4: Every strobe keeps `mem_we_n` low for exactly WP_CYC cycles.
- R5: Within a burst, `mem_we_n` stays high for at least max(DH_CYC, WPH_CYC) + SU_CYC + 1 cycles between strobes.
- R6: In a burst, each strobe falls fewer than WIN_CYC cycles after the previous one. A same-page request is accepted in the gap when at most WIN_CYC − SU_CYC − 2 cycles have passed since the last fall. Its strobe then falls SU_CYC + 1 cycles after the accepting edge.
- R7: A waiting request in another page is not accepted into an open burst. Chip-select rises in the cycle after the first gap cycle, which is WP_CYC + max(DH_CYC, WPH_CYC) + 1 cycles after the last fall. The page is the address bits above PAGE_BITS.
- R8: If no same-page request is accepted by the deadline, `in_ready` goes low. Chip-select rises WIN_CYC − SU_CYC cycles after the last fall.
- R9: After a burst, `in_ready` returns high exactly WIN_CYC + WC_CYC cycles after the last falling strobe. No strobe of a new burst falls earlier.
- R10: Each accepted request produces exactly one strobe, in acceptance order, with its own address and data on the bus at the rising edge. Chip-select falls in the cycle after an acceptance from idle, and the strobe falls SU_CYC + 1 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write request present |
| in_ready | output | 1 | Request accepted on this edge if valid |
| in_addr | input | ADDR_W | Byte address of the request |
| in_data | input | DATA_W | Byte to be written |
| mem_addr | output | ADDR_W | Address lines to the device |
| mem_dout | output | DATA_W | Data lines to the device |
| mem_drive | output | 1 | High while the data lines should be driven |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low, held high |

## Verification
The bench builds the block with 8-bit addresses, 4-byte pages, SU_CYC=2, WP_CYC=3, DH_CYC=1, WPH_CYC=2, WIN_CYC=20 and WC_CYC=15. With these values a page window is only a few strobe periods long and a programming wait lasts a few dozen cycles. This lets the bench sweep the arrival time of a follow-on request across every gap cycle, through the last accepting cycle and past it. It also runs every burst length up to a full page, in many pages. Every edge of the generated waveform is checked against cycle counts that the bench computes from the parameters.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_GAP,
    ST_BUSY
  } wr_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ewr_timer.sv
// Down-counter shared by all timed phases. A load sets the phase length
// minus one; done is high once the count reaches zero.
module ewr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/ewr_page_win.sv
// Host-side model of the device's retriggerable page window: counts the
// cycles since the last falling write strobe, saturating at the window.
module ewr_page_win #(
  parameter int WIN_CYC = 15000,
  localparam int EW = $clog2(WIN_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [EW-1:0] elapsed,
  output logic          expired
);

  localparam logic [EW-1:0] WinVal = EW'(WIN_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= WinVal;
    end else if (restart) begin
      elapsed <= '0;
    end else if (elapsed != WinVal) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  assign expired = (elapsed == WinVal);

endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7,
  parameter int SU_CYC    = 1,
  parameter int WP_CYC    = 10,
  parameter int DH_CYC    = 1,
  parameter int WPH_CYC   = 5,
  parameter int WIN_CYC   = 15000,
  parameter int WC_CYC    = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_drive,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int HOLD_CYC    = max2(DH_CYC, WPH_CYC);
  localparam int LAST_ACCEPT = WIN_CYC - SU_CYC - 2;
  localparam int MAX_PHASE   = max2(max2(SU_CYC, WP_CYC), max2(HOLD_CYC, WC_CYC));
  localparam int TW          = $clog2(MAX_PHASE + 1);
  localparam int EW          = $clog2(WIN_CYC + 1);

  wr_state_e state_q, state_d;

  logic          tmr_load, tmr_en, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          win_restart, win_expired, win_ok;
  logic [EW-1:0] win_elapsed;
  logic          same_page, accept;

  // Phase timer: one counter serves setup, strobe, hold and the busy wait.
  ewr_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .en       (tmr_en),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  ewr_page_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (win_restart),
    .elapsed (win_elapsed),
    .expired (win_expired)
  );

  assign same_page = (in_addr[ADDR_W-1:PAGE_BITS] == mem_addr[ADDR_W-1:PAGE_BITS]);
  assign win_ok    = (win_elapsed <= EW'(LAST_ACCEPT));
  assign accept    = in_valid && in_ready;

  always_comb begin
    state_d  = state_q;
    in_ready = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) state_d = ST_SETUP;
      end
      ST_SETUP:  if (tmr_done) state_d = ST_STROBE;
      ST_STROBE: if (tmr_done) state_d = ST_HOLD;
      ST_HOLD:   if (tmr_done) state_d = ST_GAP;
      ST_GAP: begin
        in_ready = win_ok && (!in_valid || same_page);
        if (in_valid && in_ready)      state_d = ST_SETUP;
        else if (in_valid || !win_ok)  state_d = ST_BUSY;
      end
      ST_BUSY:   if (tmr_done && win_expired) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q) && (state_d != ST_IDLE) && (state_d != ST_GAP);
    tmr_en   = (state_q != ST_BUSY) || win_expired;
    unique case (state_d)
      ST_SETUP:  tmr_val = TW'(SU_CYC - 1);
      ST_STROBE: tmr_val = TW'(WP_CYC - 1);
      ST_HOLD:   tmr_val = TW'(HOLD_CYC - 1);
      ST_BUSY:   tmr_val = TW'(WC_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  assign win_restart = (state_d == ST_STROBE) && (state_q != ST_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_drive <= 1'b0;
      mem_addr  <= '0;
      mem_dout  <= '0;
    end else begin
      state_q   <= state_d;
      mem_cs_n  <= (state_d == ST_IDLE) || (state_d == ST_BUSY);
      mem_we_n  <= (state_d != ST_STROBE);
      mem_drive <= (state_d != ST_IDLE) && (state_d != ST_BUSY);
      if (accept) begin
        mem_addr <= in_addr;
        mem_dout <= in_data;
      end
    end
  end

  assign mem_oe_n = 1'b1;

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n); // R3

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout))); // R3

  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mem_cs_n) |->
      (in_addr[ADDR_W-1:PAGE_BITS] == mem_addr[ADDR_W-1:PAGE_BITS])); // R7

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> !in_ready); // R9

  AST_HS_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!mem_cs_n && mem_we_n && mem_drive)); // R10

endmodule

// File: tb/eeprom_wr_seq_test.sv
module eeprom_wr_seq_test;

  localparam int AW = 8, DW = 8, PB = 2;
  localparam int SU = 2, WP = 3, DH = 1, WPH = 2, WIN = 20, WC = 15;
  localparam int HOLD = (DH > WPH) ? DH : WPH;
  localparam int LAST = WIN - SU - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic          mem_drive, mem_cs_n, mem_we_n, mem_oe_n;

  eeprom_wr_seq #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .SU_CYC(SU), .WP_CYC(WP),
    .DH_CYC(DH), .WPH_CYC(WPH), .WIN_CYC(WIN), .WC_CYC(WC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_drive(mem_drive), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int bound);
    n_chk++;
    if (act < bound) begin
      n_fail++;
      $display("FAIL %s: got %0d expected >= %0d", req, act, bound);
    end
  endtask

  task automatic chk_lt(input string req, input int act, input int bound);
    n_chk++;
    if (act >= bound) begin
      n_fail++;
      $display("FAIL %s: got %0d expected < %0d", req, act, bound);
    end
  endtask

  // expected write order
  logic [AW-1:0] q_addr [0:511];
  logic [DW-1:0] q_data [0:511];
  int q_wr = 0, q_rd = 0;

  // waveform monitor state
  logic p_we = 1'b1, p_cs = 1'b1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_data = '0;
  int stable = 0, last_fall = 0, last_rise = 0, cs_rise = 0, fall_cnt = 0;
  int burst_pg = 0;
  bit burst_open = 0, hold_pend = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n && mem_drive)
        stable = (mem_addr == p_addr && mem_dout == p_data && !p_cs) ? stable + 1 : 1;
      else
        stable = 0;
      if (hold_pend && (mem_addr != p_addr || mem_dout != p_data || mem_cs_n || !mem_drive)) begin
        chk_ge("R3 hold after rise", cyc - last_rise, HOLD);
        hold_pend = 0;
      end
      if (p_we && !mem_we_n) begin
        chk("R2 oe_n at strobe", int'(mem_oe_n), 1);
        chk("R3 cs_n low at strobe", int'(mem_cs_n), 0);
        chk_ge("R3 setup before fall", stable - 1, SU);
        if (burst_open) begin
          chk_lt("R6 fall inside window", cyc - last_fall, WIN);
          chk("R7 page kept in burst", int'(mem_addr >> PB), burst_pg);
          chk_ge("R5 high time", cyc - last_rise, HOLD + SU + 1);
        end else if (fall_cnt > 0) begin
          chk_ge("R9 no write while busy", cyc - last_fall, WIN + WC);
        end
        last_fall = cyc;
        fall_cnt++;
        burst_open = 1;
        burst_pg = int'(mem_addr >> PB);
      end
      if (!p_we && mem_we_n) begin
        chk("R4 strobe width", cyc - last_fall, WP);
        chk("R10 address at rise", int'(mem_addr), int'(q_addr[q_rd]));
        chk("R10 data at rise", int'(mem_dout), int'(q_data[q_rd]));
        q_rd++;
        last_rise = cyc;
        hold_pend = 1;
      end
      if (!p_cs && mem_cs_n) begin
        burst_open = 0;
        cs_rise = cyc;
      end
      p_we = mem_we_n;
      p_cs = mem_cs_n;
      p_addr = mem_addr;
      p_data = mem_dout;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, output int hs);
    in_valid = 1'b1;
    in_addr = a;
    in_data = d;
    q_addr[q_wr] = a;
    q_data[q_wr] = d;
    q_wr++;
    #1;
    while (!in_ready) tick();
    hs = cyc;
    @(posedge clk);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(in_ready && mem_cs_n)) tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: got %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int hs, hs2, f1, f2, e, nf;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cs_n in reset", int'(mem_cs_n), 1);
    chk("R1 we_n in reset", int'(mem_we_n), 1);
    rst_n = 1'b1;
    tick();
    chk("R1 cs_n after reset", int'(mem_cs_n), 1);
    chk("R1 we_n after reset", int'(mem_we_n), 1);
    chk("R1 drive after reset", int'(mem_drive), 0);
    chk("R1 ready after reset", int'(in_ready), 1);
    chk("R2 oe_n after reset", int'(mem_oe_n), 1);

    // single write, burst closed by idle deadline
    send(8'h40, 8'h5A, hs);
    chk("R10 cs_n falls after accept", int'(mem_cs_n), 0);
    f1 = hs + 1 + SU;
    while (mem_cs_n == 1'b0) tick();
    chk("R10 first fall timing", last_fall, f1);
    chk("R8 cs rise after idle close", cs_rise - f1, WIN - SU);
    chk("R8 ready low while busy", int'(in_ready), 0);
    while (!in_ready) tick();
    chk("R9 ready returns", cyc - f1, WIN + WC);

    // page change closes the burst
    send(8'h10, 8'h01, hs);
    send(8'h11, 8'h02, hs);
    f2 = hs + 1 + SU;
    send(8'h24, 8'h03, hs2);
    chk("R7 cs rise on page change", cs_rise - f2, WP + HOLD + 1);
    chk("R7 R9 other page accepted after wait", hs2 - f2, WIN + WC);
    wait_idle();

    // sweep the arrival of a same-page follow-on across the gap
    for (int d = 0; d <= LAST - WP - HOLD + 2; d++) begin
      wait_idle();
      send(AW'(4 * d), DW'(8'hA0 + d), hs);
      f1 = hs + 1 + SU;
      e = WP + HOLD + d;
      while (cyc < f1 + e) tick();
      chk("R10 sweep first fall", last_fall, f1);
      nf = fall_cnt;
      if (e <= LAST) begin
        chk("R6 ready open in window", int'(in_ready), 1);
        send(AW'(4 * d + 1), DW'(8'hC0 + d), hs2);
        chk("R6 accepted at arrival", hs2 - f1, e);
        while (fall_cnt == nf) tick();
        chk("R6 follow-on fall", last_fall - f1, e + 1 + SU);
      end else begin
        chk("R8 ready closed past deadline", int'(in_ready), 0);
        send(AW'(4 * d + 1), DW'(8'hC0 + d), hs2);
        chk("R9 late request waits", hs2 - f1, WIN + WC);
        while (fall_cnt == nf) tick();
        chk("R9 late request fall", last_fall - f1, WIN + WC + 1 + SU);
      end
    end

    // burst lengths 1..4 in many pages
    for (int len = 1; len <= 4; len++) begin
      for (int pg = 0; pg < 8; pg++) begin
        wait_idle();
        nf = fall_cnt;
        for (int k = 0; k < len; k++)
          send(AW'((len * 8 + pg) * 4 + k), DW'(len * 37 + pg * 5 + k), hs);
        while (!mem_cs_n) tick();
        chk("R10 one strobe per request", fall_cnt - nf, len);
        chk("R8 burst closes at deadline", cs_rise - last_fall, WIN - SU);
        f1 = last_fall;
        while (!in_ready) tick();
        chk("R9 ready after burst", cyc - f1, WIN + WC);
      end
    end

    chk("R10 all requests written", q_rd, q_wr);
    finished = 1;
    summary();
    $finish;
  end

endmodule